// File: doc/BRIEF.md
# MDIO Management Command Controller

This block gives a processor register-level access to the serial management interface of an Ethernet PHY. Software loads a data register, then writes a command word carrying the PHY address, the register number, a clock-range select, a write flag and a go/busy flag. Writing the command with the go bit set launches one management frame on the MDC/MDIO pin pair. The busy bit stays high while the frame runs and drops by itself when it ends.

Each frame is 64 MDC periods long. It starts with a run of ones as preamble. Then come the start code, the opcode, both addresses MSB first, a two-bit turnaround and sixteen data bits. For a read, the controller lets go of MDIO from the turnaround onward and shifts in the PHY's answer on rising MDC edges. That answer is in the data register by the time busy reads zero. The MDC rate comes from the system clock through a divider whose half period the clock-range field selects. Command writes that arrive while a frame is in flight are dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, busy reads 0, the command and data read-back ports read 0, MDC is low and MDIO is not driven (mdio_oe low).
- R2: The command word layout is: bit 0 go/busy, bit 1 write flag, bits [4:2] clock-range select, bits [9:5] register number, bits [14:10] PHY address. A command write with bit 0 set makes busy read 1 from the next cycle, and the stored fields read back unchanged.
- R3: A write frame puts on MDIO, MSB first, 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10 and the 16 bits of the data register, with mdio_oe high for all 64 bits.
- R4: A read frame carries opcode 10. mdio_oe is high for the first 46 bits and low for the turnaround and the 16 data bit times.
- R5: In a read, the data bits are sampled on rising MDC edges, MSB first. The 16-bit result appears on the data read-back port in the same cycle that busy returns to 0.
- R6: Every frame has exactly 64 rising MDC edges. Busy clears at the final falling edge, and MDC stays low while busy is 0.
- R7: MDC is high for MIN_HALF·2^sel system clock cycles and low for the same count, where sel is the clock-range field.
- R8: A command write while busy is 1 is ignored: the read-back fields stay the same, and the running frame goes on with its original content.
- R9: A command write with bit 0 clear stores the fields but starts no frame: busy stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 15 | Command word to write |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data word to write |
| cmd_rdata | output | 15 | Command read-back, bit 0 is live busy |
| data_rdata | output | 16 | Data register read-back (read result after a read) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The bench builds the controller with MIN_HALF = 2, a 32-bit preamble and a 3-bit clock-range field. With those values a frame at select 0 lasts only 256 system cycles, so full write and read frames, a read that returns a data pattern with both edge bits set, a blocked mid-frame command and divider widths at selects 0 and 2 all fit well inside the run. Keeping the preamble at full length means the bench checks the real 64-bit frame position by position, and the turnaround boundary sits at bit 46.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      MDIO_OP_WRITE = 2'b01,
      MDIO_OP_READ  = 2'b10
   } mdio_op_e;

   localparam logic [1:0] MDIO_SOF      = 2'b01;
   localparam logic [1:0] MDIO_TA_DRIVE = 2'b10;

   localparam int MDIO_SOF_BITS = 2;
   localparam int MDIO_OP_BITS  = 2;
   localparam int MDIO_TA_BITS  = 2;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int SEL_W    = 3,
   parameter int MIN_HALF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);

   localparam int NSEL     = 1 << SEL_W;
   localparam int MAX_HALF = MIN_HALF << (NSEL - 1);
   localparam int CNT_W    = $clog2(MAX_HALF) + 1;

   logic [CNT_W-1:0] half_lim [NSEL];
   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   for (genvar g = 0; g < NSEL; g++) begin : g_half
      assign half_lim[g] = CNT_W'((MIN_HALF << g) - 1);
   end

   assign wrap     = run && (cnt_q == half_lim[sel]);
   assign rise_stb = wrap && !mdc_q;
   assign fall_stb = wrap && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7: MDC only rises while the divider is running
   assert_rise_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc_q) |-> $past(run));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              active,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              mdio_o,
   output logic              mdio_oe
);

   localparam int TA_START   = PRE_LEN + MDIO_SOF_BITS + MDIO_OP_BITS + PHY_AW + REG_AW;
   localparam int DATA_START = TA_START + MDIO_TA_BITS;
   localparam int FRAME_LEN  = DATA_START + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_LEN);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_START);
   localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_START);

   logic [FRAME_LEN-1:0] tx_sr;
   logic [DATA_W-1:0]    rx_sr;
   logic [IDX_W-1:0]     idx_q;
   logic                 active_q;
   logic                 wr_q;
   mdio_op_e             op;

   assign op = is_write ? MDIO_OP_WRITE : MDIO_OP_READ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         idx_q    <= '0;
         active_q <= 1'b0;
         wr_q     <= 1'b0;
      end else if (start && !active_q) begin
         tx_sr    <= {{PRE_LEN{1'b1}}, MDIO_SOF, op, phy_addr, reg_addr,
                      MDIO_TA_DRIVE, wdata};
         idx_q    <= '0;
         active_q <= 1'b1;
         wr_q     <= is_write;
      end else if (active_q && fall_stb) begin
         if (idx_q == IDX_LAST) begin
            active_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
            tx_sr <= {tx_sr[FRAME_LEN-2:0], 1'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr <= '0;
      end else if (active_q && rise_stb && !wr_q && (idx_q >= IDX_DATA)) begin
         rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
      end
   end

   assign active  = active_q;
   assign done    = active_q && fall_stb && (idx_q == IDX_LAST);
   assign rdata   = rx_sr;
   assign mdio_o  = tx_sr[FRAME_LEN-1];
   assign mdio_oe = active_q && (wr_q || (idx_q < IDX_TA));

   // R6: a frame only ends after its last bit
   assert_end_at_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> ($past(idx_q) == IDX_LAST));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
   parameter int PHY_AW   = 5,
   parameter int REG_AW   = 5,
   parameter int DATA_W   = 16,
   parameter int SEL_W    = 3,
   parameter int MIN_HALF = 2,
   parameter int PRE_LEN  = 32,
   localparam int CMD_W   = 2 + SEL_W + REG_AW + PHY_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [CMD_W-1:0]  cmd_rdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe
);

   localparam int GO_BIT  = 0;
   localparam int WR_BIT  = 1;
   localparam int SEL_LSB = 2;
   localparam int REG_LSB = SEL_LSB + SEL_W;
   localparam int PHY_LSB = REG_LSB + REG_AW;

   if (MIN_HALF < 1) begin : g_bad_half
      $error("MIN_HALF must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie between 1 and 4");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end

   logic [CMD_W-1:1]  fields_q;
   logic [DATA_W-1:0] data_q;
   logic              busy;
   logic              start;
   logic              done;
   logic              rise_stb;
   logic              fall_stb;
   logic [DATA_W-1:0] rx_word;

   assign start = cmd_wr && !busy && cmd_wdata[GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields_q <= '0;
      end else if (cmd_wr && !busy) begin
         fields_q <= cmd_wdata[CMD_W-1:1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (done && !fields_q[WR_BIT]) begin
         data_q <= rx_word;
      end else if (data_wr) begin
         data_q <= data_wdata;
      end
   end

   mdio_clkdiv #(
      .SEL_W    (SEL_W),
      .MIN_HALF (MIN_HALF)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .sel      (fields_q[SEL_LSB +: SEL_W]),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_write (cmd_wdata[WR_BIT]),
      .phy_addr (cmd_wdata[PHY_LSB +: PHY_AW]),
      .reg_addr (cmd_wdata[REG_LSB +: REG_AW]),
      .wdata    (data_q),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .active   (busy),
      .done     (done),
      .rdata    (rx_word),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   assign cmd_rdata  = {fields_q, busy};
   assign data_rdata = data_q;

   // R6: MDC rests low whenever no frame is running
   assert_idle_mdc_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R8: command writes during a frame leave the stored fields alone
   assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> $stable(fields_q));

   // R3: every frame opens by driving a preamble one
   assert_frame_opens_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mdio_oe && mdio_o));

   // R9: a frame starts only from a command with the go bit set
   assert_go_needed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_wr) && $past(cmd_wdata[GO_BIT])));

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;

   localparam int MIN_HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [14:0] cmd_wdata = '0;
   logic        data_wr = 1'b0;
   logic [15:0] data_wdata = '0;
   logic [14:0] cmd_rdata;
   logic [15:0] data_rdata;
   logic        mdc;
   logic        mdio_i;
   logic        mdio_o;
   logic        mdio_oe;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // PHY model state
   int          rises = 0;
   logic [63:0] cap_bit = '0;
   logic [63:0] cap_oe = '0;
   logic [15:0] resp_val = '0;
   bit          resp_en = 1'b0;
   bit          phy_drv = 1'b0;
   logic        phy_val = 1'b1;
   int          clashes = 0;

   always #10 clk = ~clk;

   mdio_mgmt_ctrl #(
      .MIN_HALF (MIN_HALF),
      .PRE_LEN  (32),
      .SEL_W    (3)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_wdata  (cmd_wdata),
      .data_wr    (data_wr),
      .data_wdata (data_wdata),
      .cmd_rdata  (cmd_rdata),
      .data_rdata (data_rdata),
      .mdc        (mdc),
      .mdio_i     (mdio_i),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe)
   );

   assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

   always @(posedge mdc) begin
      if (rises < 64) begin
         cap_bit[63 - rises] = mdio_o;
         cap_oe[63 - rises]  = mdio_oe;
      end
      if (mdio_oe && phy_drv) clashes = clashes + 1;
      rises = rises + 1;
   end

   always @(negedge mdc) begin
      if (resp_en && rises >= 48 && rises <= 63) begin
         phy_drv = 1'b1;
         phy_val = resp_val[63 - rises];
      end else begin
         phy_drv = 1'b0;
      end
   end

   function automatic logic [14:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [2:0] sel, input logic wr,
                                          input logic go);
      return {phy, rg, sel, wr, go};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic mon_clear();
      rises   = 0;
      cap_bit = '0;
      cap_oe  = '0;
      clashes = 0;
   endtask

   task automatic write_cmd(input logic [14:0] w);
      @(negedge clk);
      cmd_wr    = 1'b1;
      cmd_wdata = w;
      @(negedge clk);
      cmd_wr    = 1'b0;
   endtask

   task automatic write_data(input logic [15:0] d);
      @(negedge clk);
      data_wr    = 1'b1;
      data_wdata = d;
      @(negedge clk);
      data_wr    = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (cmd_rdata[0] && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(!cmd_rdata[0], tag, 64'(cmd_rdata[0]), 64'd0);
   endtask

   task automatic test_reset();
      check(cmd_rdata == '0, "R1 cmd readback", 64'(cmd_rdata), 64'd0);
      check(data_rdata == '0, "R1 data readback", 64'(data_rdata), 64'd0);
      check(!mdc && !mdio_oe, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
   endtask

   task automatic test_write(input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] d);
      logic [63:0] exp;
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
      write_data(d);
      mon_clear();
      write_cmd(mk_cmd(phy, rg, 3'd0, 1'b1, 1'b1));
      check(cmd_rdata == mk_cmd(phy, rg, 3'd0, 1'b1, 1'b1), "R2 launch readback",
            64'(cmd_rdata), 64'(mk_cmd(phy, rg, 3'd0, 1'b1, 1'b1)));
      wait_idle("R6 write busy clears");
      check(rises == 64, "R6 write rising edges", 64'(rises), 64'd64);
      check(cap_bit == exp, "R3 write frame bits", cap_bit, exp);
      check(cap_oe == '1, "R3 write drive enable", cap_oe, '1);
      check(!mdc, "R6 mdc low after frame", 64'(mdc), 64'd0);
   endtask

   task automatic test_read(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] v);
      logic [45:0] exp_hdr;
      exp_hdr  = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
      resp_val = v;
      resp_en  = 1'b1;
      mon_clear();
      write_cmd(mk_cmd(phy, rg, 3'd0, 1'b0, 1'b1));
      check(cmd_rdata[0] == 1'b1, "R2 read busy set", 64'(cmd_rdata[0]), 64'd1);
      wait_idle("R6 read busy clears");
      check(cap_bit[63:18] == exp_hdr, "R4 read header bits", 64'(cap_bit[63:18]),
            64'(exp_hdr));
      check(cap_oe == {{46{1'b1}}, 18'd0}, "R4 read release", cap_oe,
            {{46{1'b1}}, 18'd0});
      check(data_rdata == v, "R5 read data", 64'(data_rdata), 64'(v));
      check(clashes == 0, "R4 no drive clash", 64'(clashes), 64'd0);
      resp_en = 1'b0;
   endtask

   task automatic test_divider(input logic [2:0] sel);
      int hi = 0;
      int lo = 0;
      int exp_h;
      exp_h = MIN_HALF << sel;
      mon_clear();
      write_cmd(mk_cmd(5'd3, 5'd4, sel, 1'b1, 1'b1));
      repeat (3) @(posedge mdc);
      while (1) begin
         @(negedge clk);
         if (mdc) hi++;
         else break;
      end
      lo = 1;
      while (1) begin
         @(negedge clk);
         if (!mdc) lo++;
         else break;
      end
      check(hi == exp_h, "R7 mdc high width", 64'(hi), 64'(exp_h));
      check(lo == exp_h, "R7 mdc low width", 64'(lo), 64'(exp_h));
      wait_idle("R7 divider frame ends");
      check(rises == 64, "R6 rising edges at slow clock", 64'(rises), 64'd64);
   endtask

   task automatic test_busy_ignore();
      logic [63:0] exp;
      logic [14:0] first;
      first = mk_cmd(5'd9, 5'd2, 3'd0, 1'b1, 1'b1);
      exp   = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd2, 2'b10, 16'h5A3C};
      write_data(16'h5A3C);
      mon_clear();
      write_cmd(first);
      repeat (40) @(negedge clk);
      write_cmd(mk_cmd(5'd30, 5'd17, 3'd5, 1'b0, 1'b1));
      check(cmd_rdata == first, "R8 fields unchanged", 64'(cmd_rdata), 64'(first));
      wait_idle("R8 frame ends");
      check(cap_bit == exp, "R8 frame content kept", cap_bit, exp);
      check(rises == 64, "R8 single frame", 64'(rises), 64'd64);
   endtask

   task automatic test_no_go();
      logic [14:0] w;
      w = mk_cmd(5'd21, 5'd11, 3'd6, 1'b1, 1'b0);
      mon_clear();
      write_cmd(w);
      repeat (50) @(negedge clk);
      check(cmd_rdata == w, "R9 fields stored, idle", 64'(cmd_rdata), 64'(w));
      check(rises == 0, "R9 no mdc activity", 64'(rises), 64'd0);
      check(cmd_rdata[4:2] == 3'd6 && cmd_rdata[14:10] == 5'd21, "R2 field positions",
            64'(cmd_rdata), 64'(w));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_write(5'd1, 5'd0, 16'hA5F0);
      test_write(5'd31, 5'd31, 16'h8001);
      test_read(5'd7, 5'd1, 16'hC3A5);
      test_read(5'd16, 5'd26, 16'h8001);
      test_divider(3'd0);
      test_divider(3'd2);
      test_busy_ignore();
      test_no_go();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule